// File: doc/BRIEF.md
# Reset and Power-Good Sequencer

This block turns a handful of board-level reset and supply indications into the reset and power-good outputs a system board needs. A main-rail-good and a standby-rail-good indication each start their own delay timer. The main timer drives two identical power-good outputs after a selectable 100 to 400 ms. The standby timer releases a resume reset 66 ms after standby becomes good. If a rail-good input drops, its output falls in the same cycle and its timer starts again from zero.

A front-panel reset button (active low) is debounced for 50 ms. A routing input decides where the debounced button acts. When the routing input is 1, it joins the bus reset on all five PCI reset outputs. When the routing input is 0, it pulls the two power-good outputs low instead. The last two PCI resets also take in a secondary reset input. Every merged output is the AND of its active-low sources. All inputs are taken to be synchronous to `clk`. The parameter `CYCLES_PER_MS` sets how many clock cycles make up one millisecond, so a simulation can use a very small value.

Top module: `rst_pg_seq`

## Requirements
- R1: A new level on `btn_n` reaches the debounced button state only after it has been sampled unchanged on exactly 50*CYCLES_PER_MS consecutive clock edges. The new state is visible after the last of those edges. The debounced state resets to released (1).
- R2: Any return of `btn_n` to the current debounced level before the count completes restarts the count. A full 50 ms of stable new level is then needed again.
- R3: With `btn_to_pci`=1, a pressed (0) debounced button drives all five `pci_rst_n` bits low, and the power-good outputs do not depend on the button.
- R4: With `btn_to_pci`=0, a pressed debounced button drives `pg_main_a` and `pg_main_b` low, and `pci_rst_n` does not depend on the button.
- R5: `pci_rst_n[2:0]` each equal the AND of `bus_rst_n` and the routed button. `pci_rst_n[4:3]` each equal that value ANDed with `aux_rst_n`.
- R6: `pg_main_a` and `pg_main_b` rise (`pg_dly`+1)*100*CYCLES_PER_MS clock edges after `main_ok` is first sampled high. The encoding is 0=100 ms, 1=200 ms, 2=300 ms and 3=400 ms.
- R7: `rsm_rst_n` rises 66*CYCLES_PER_MS clock edges after `stby_ok` is first sampled high.
- R8: A low `main_ok` forces both power-good outputs low, and a low `stby_ok` forces `rsm_rst_n` low, in the same cycle. The delay restarts in full once the input returns high.
- R9: While `rst_n` is low, both power-good outputs and `rsm_rst_n` are low, and the button reads released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| main_ok | input | 1 | Main rail good |
| stby_ok | input | 1 | Standby rail good |
| btn_n | input | 1 | Reset button, active low |
| bus_rst_n | input | 1 | Bus reset, active low |
| aux_rst_n | input | 1 | Secondary PCI reset input, active low |
| btn_to_pci | input | 1 | 1: button feeds PCI resets; 0: button feeds power-good |
| pg_dly | input | 2 | Main power-good delay select |
| pg_main_a | output | 1 | Main power-good, copy A |
| pg_main_b | output | 1 | Main power-good, copy B |
| rsm_rst_n | output | 1 | Resume reset, active low |
| pci_rst_n | output | 5 | Combined PCI resets, active low |

## Verification
Each of the four delay codes is timed by sampling one edge before and exactly at the expected rise, which tells a correct delay apart from an off-by-one or a wrongly decoded code. With the button held debounced-pressed and then released, every combination of routing bit, bus reset and secondary reset is swept. That sweep separates the two routing modes and shows which outputs merge the secondary input. Button presses that end one edge early, and presses interrupted by a one-cycle bounce, separate a true restart of the debounce count from a count that only pauses. Dropping each rail-good input shows that the output falls at once and that the full delay is needed again.

// File: rtl/rst_pg_pkg.sv
package rst_pg_pkg;
  typedef enum logic [1:0] {
    PG_100MS = 2'd0,
    PG_200MS = 2'd1,
    PG_300MS = 2'd2,
    PG_400MS = 2'd3
  } pg_dly_e;

  // cycles of the main power-good delay for a given code
  function automatic int unsigned pg_delay_cycles(input logic [1:0] code,
                                                  input int unsigned step_cyc);
    return (int'(code) + 1) * step_cyc;
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned STABLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic deb_n
);
  localparam int unsigned CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= 1'b1;
    end else if (raw_n == state_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= LAST) begin
      cnt_q   <= '0;
      state_q <= raw_n;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign deb_n = state_q;
endmodule

// File: rtl/rail_delay.sv
module rail_delay #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ok,
  input  logic [CW-1:0] limit,
  output logic          good
);
  logic [CW-1:0] cnt_q;
  logic          good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (!ok) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (!good_q) begin
      if (cnt_q >= limit - 1'b1) begin
        cnt_q  <= '0;
        good_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // a lost rail drops the output in the same cycle
  assign good = good_q & ok;
endmodule

// File: rtl/reset_merge.sv
module reset_merge #(
  parameter int unsigned N_OUT = 5,
  parameter int unsigned N_AUX = 2
) (
  input  logic             bus_rst_n,
  input  logic             btn_rst_n,
  input  logic             aux_rst_n,
  output logic [N_OUT-1:0] rst_out_n
);
  localparam int unsigned FIRST_AUX = N_OUT - N_AUX;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    if (i >= FIRST_AUX) begin : g_aux
      assign rst_out_n[i] = bus_rst_n & btn_rst_n & aux_rst_n;
    end else begin : g_plain
      assign rst_out_n[i] = bus_rst_n & btn_rst_n;
    end
  end
endmodule

// File: rtl/rst_pg_seq.sv
module rst_pg_seq
  import rst_pg_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 50000,
  parameter int unsigned DEB_MS        = 50,
  parameter int unsigned RSM_MS        = 66,
  parameter int unsigned PG_STEP_MS    = 100,
  parameter int unsigned N_PCI         = 5,
  parameter int unsigned N_AUX         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_ok,
  input  logic             stby_ok,
  input  logic             btn_n,
  input  logic             bus_rst_n,
  input  logic             aux_rst_n,
  input  logic             btn_to_pci,
  input  logic [1:0]       pg_dly,
  output logic             pg_main_a,
  output logic             pg_main_b,
  output logic             rsm_rst_n,
  output logic [N_PCI-1:0] pci_rst_n
);
  localparam int unsigned DEB_CYC     = DEB_MS * CYCLES_PER_MS;
  localparam int unsigned RSM_CYC     = RSM_MS * CYCLES_PER_MS;
  localparam int unsigned PG_STEP_CYC = PG_STEP_MS * CYCLES_PER_MS;
  localparam int unsigned PG_MAX_CYC  = 4 * PG_STEP_CYC;
  localparam int unsigned MAX_CYC     = (PG_MAX_CYC > RSM_CYC) ? PG_MAX_CYC : RSM_CYC;
  localparam int unsigned TW          = $clog2(MAX_CYC + 1);

  logic          btn_deb;
  logic          main_good;
  logic [TW-1:0] pg_limit;
  logic          btn_pci_n;
  logic          btn_pg;

  btn_debounce #(.STABLE_CYC(DEB_CYC)) deb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_n (btn_n),
    .deb_n (btn_deb)
  );

  assign pg_limit = TW'(pg_delay_cycles(pg_dly, PG_STEP_CYC));

  rail_delay #(.CW(TW)) main_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ok    (main_ok),
    .limit (pg_limit),
    .good  (main_good)
  );

  rail_delay #(.CW(TW)) stby_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ok    (stby_ok),
    .limit (TW'(RSM_CYC)),
    .good  (rsm_rst_n)
  );

  // routing of the debounced button
  assign btn_pci_n = btn_to_pci ? btn_deb : 1'b1;
  assign btn_pg    = btn_to_pci ? 1'b1 : btn_deb;

  assign pg_main_a = main_good & btn_pg;
  assign pg_main_b = main_good & btn_pg;

  reset_merge #(.N_OUT(N_PCI), .N_AUX(N_AUX)) merge_i (
    .bus_rst_n (bus_rst_n),
    .btn_rst_n (btn_pci_n),
    .aux_rst_n (aux_rst_n),
    .rst_out_n (pci_rst_n)
  );
endmodule

// File: rtl/rst_pg_seq_chk.sv
module rst_pg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_ok,
  input logic       stby_ok,
  input logic       btn_n,
  input logic       bus_rst_n,
  input logic       aux_rst_n,
  input logic       btn_to_pci,
  input logic       btn_deb,
  input logic       pg_main_a,
  input logic       pg_main_b,
  input logic       rsm_rst_n,
  input logic [4:0] pci_rst_n
);
  assert_deb_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(btn_deb) |-> (btn_deb == $past(btn_n)));

  assert_btn_pci_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_to_pci && !btn_deb) |-> (pci_rst_n == 5'b0));

  assert_btn_pg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_to_pci && !btn_deb) |-> (!pg_main_a && !pg_main_b));

  assert_pci_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_to_pci |-> (pci_rst_n[0] == bus_rst_n));

  assert_bus_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |-> (pci_rst_n == 5'b0));

  assert_aux_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_rst_n |-> (pci_rst_n[4:3] == 2'b0));

  assert_pg_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_main_a) |-> $past(main_ok));

  assert_pg_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok |-> (!pg_main_a && !pg_main_b));

  assert_rsm_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_ok |-> !rsm_rst_n);
endmodule

bind rst_pg_seq rst_pg_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .main_ok    (main_ok),
  .stby_ok    (stby_ok),
  .btn_n      (btn_n),
  .bus_rst_n  (bus_rst_n),
  .aux_rst_n  (aux_rst_n),
  .btn_to_pci (btn_to_pci),
  .btn_deb    (btn_deb),
  .pg_main_a  (pg_main_a),
  .pg_main_b  (pg_main_b),
  .rsm_rst_n  (rsm_rst_n),
  .pci_rst_n  (pci_rst_n)
);

// File: tb/rst_pg_seq_tb_top.sv
`timescale 1ns/1ps
module rst_pg_seq_tb_top;
  localparam int CPM  = 2;
  localparam int DEB  = 50 * CPM;
  localparam int RSM  = 66 * CPM;
  localparam int STEP = 100 * CPM;

  logic       clk = 1'b0;
  logic       rst_n, main_ok, stby_ok, btn_n, bus_rst_n, aux_rst_n, btn_to_pci;
  logic [1:0] pg_dly;
  logic       pg_main_a, pg_main_b, rsm_rst_n;
  logic [4:0] pci_rst_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rst_pg_seq #(.CYCLES_PER_MS(CPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .stby_ok(stby_ok),
    .btn_n(btn_n), .bus_rst_n(bus_rst_n), .aux_rst_n(aux_rst_n),
    .btn_to_pci(btn_to_pci), .pg_dly(pg_dly),
    .pg_main_a(pg_main_a), .pg_main_b(pg_main_b),
    .rsm_rst_n(rsm_rst_n), .pci_rst_n(pci_rst_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pgv();
    return {6'b0, pg_main_a, pg_main_b};
  endfunction

  // expected merged vector from the requirements
  function automatic logic [4:0] exp_pci(input logic r, input logic b,
                                         input logic a, input logic d);
    logic lo;
    lo = b & (r ? d : 1'b1);
    return {{2{lo & a}}, {3{lo}}};
  endfunction

  initial begin
    int lim;
    rst_n = 0; main_ok = 0; stby_ok = 0; btn_n = 1; bus_rst_n = 1;
    aux_rst_n = 1; btn_to_pci = 1; pg_dly = 2'd3;
    step(3);
    chk("R9 pg in reset", pgv(), 8'h0);
    chk("R9 rsm in reset", {7'b0, rsm_rst_n}, 8'h0);
    chk("R9 pci released", {3'b0, pci_rst_n}, 8'h1f);
    rst_n = 1;
    step(2);

    // R7 resume reset delay
    stby_ok = 1;
    step(RSM - 1);
    chk("R7 rsm before", {7'b0, rsm_rst_n}, 8'h0);
    step(1);
    chk("R7 rsm at delay", {7'b0, rsm_rst_n}, 8'h1);

    // R6 every delay code
    for (int s = 0; s < 4; s++) begin
      main_ok = 0;
      step(2);
      pg_dly = 2'(s);
      main_ok = 1;
      lim = (s + 1) * STEP;
      step(lim - 1);
      chk("R6 pg before delay", pgv(), 8'h0);
      step(1);
      chk("R6 pg at delay", pgv(), 8'h3);
    end

    // R8 main rail loss and restart (code 3 = 400 ms)
    main_ok = 0;
    #1;
    chk("R8 pg drop same cycle", pgv(), 8'h0);
    step(1);
    main_ok = 1;
    step(4 * STEP - 1);
    chk("R8 pg full restart before", pgv(), 8'h0);
    step(1);
    chk("R8 pg full restart at", pgv(), 8'h3);
    stby_ok = 0;
    #1;
    chk("R8 rsm drop same cycle", {7'b0, rsm_rst_n}, 8'h0);
    step(1);
    stby_ok = 1;
    step(RSM - 1);
    chk("R8 rsm restart before", {7'b0, rsm_rst_n}, 8'h0);
    step(1);
    chk("R8 rsm restart at", {7'b0, rsm_rst_n}, 8'h1);

    // R1 debounce press and release, route to PCI
    btn_to_pci = 1;
    btn_n = 0;
    step(DEB - 1);
    chk("R1 press not yet", {3'b0, pci_rst_n}, 8'h1f);
    step(1);
    chk("R1 R3 press taken", {3'b0, pci_rst_n}, 8'h00);
    chk("R3 pg unaffected", pgv(), 8'h3);
    btn_n = 1;
    step(DEB - 1);
    chk("R1 release not yet", {3'b0, pci_rst_n}, 8'h00);
    step(1);
    chk("R1 release taken", {3'b0, pci_rst_n}, 8'h1f);

    // R2 bounce restarts the count
    btn_n = 0;
    step(DEB - 10);
    btn_n = 1;
    step(1);
    btn_n = 0;
    step(DEB - 1);
    chk("R2 restarted count", {3'b0, pci_rst_n}, 8'h1f);
    step(1);
    chk("R2 press after restart", {3'b0, pci_rst_n}, 8'h00);

    // R3 R4 R5 sweep with button pressed (deb=0)
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 2; a++) begin
          btn_to_pci = 1'(r); bus_rst_n = 1'(b); aux_rst_n = 1'(a);
          #1;
          chk("R5 R3 R4 pci pressed", {3'b0, pci_rst_n},
              {3'b0, exp_pci(1'(r), 1'(b), 1'(a), 1'b0)});
          chk("R3 R4 pg pressed", pgv(), r ? 8'h3 : 8'h0);
          step(1);
        end

    // release and sweep again (deb=1)
    bus_rst_n = 1; aux_rst_n = 1;
    btn_n = 1;
    step(DEB);
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 2; a++) begin
          btn_to_pci = 1'(r); bus_rst_n = 1'(b); aux_rst_n = 1'(a);
          #1;
          chk("R5 pci released", {3'b0, pci_rst_n},
              {3'b0, exp_pci(1'(r), 1'(b), 1'(a), 1'b1)});
          chk("R4 pg released", pgv(), 8'h3);
          step(1);
        end

    // R4 power-good returns after release with routing 0
    btn_to_pci = 0; bus_rst_n = 1; aux_rst_n = 1;
    btn_n = 0;
    step(DEB);
    chk("R4 pg pulled low", pgv(), 8'h0);
    chk("R4 pci untouched", {3'b0, pci_rst_n}, 8'h1f);
    btn_n = 1;
    step(DEB);
    chk("R4 pg back", pgv(), 8'h3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule